// File: doc/BRIEF.md
# Station Management Port with Built-in PHY Register Model

This block gives a processor the same register-level view of a transceiver's management registers that it would have through a serial management bus, but the transceiver registers live inside the block. Software first loads a selector register with a PHY address and a register number. It then either writes 16-bit data through a data register, which lands in the selected PHY register, or writes a command that copies the selected PHY register into a status register it can read back.

The modelled transceiver answers at one PHY address only. At any other address a read returns all ones and a write does nothing. The model has the usual side effects of the basic control register. A self-clearing reset bit reloads the identity and capability words. An auto-negotiation start bit finishes at once. The link-status and negotiation-complete flags in the basic status register follow a link-up input. A soft reset of the surrounding MAC reloads the same defaults.

Top module: `mdio_phy_emu`

## Requirements
- R1: The selector register at byte offset 0x28 keeps the PHY register number in bits 4:0 and the PHY address in bits 12:8. It reads back with every other bit zero.
- R2: A read command at a PHY address other than 1 loads 0xFFFF into the status register.
- R3: A data write at a PHY address other than 1 changes no PHY register.
- R4: A write to the command register at 0x24 with bit 0 set copies the selected PHY register into the status register at 0x30, with bits 31:16 zero. A command write with bit 0 clear leaves the status register unchanged.
- R5: A write to the data register at 0x2C stores its bits 15:0 into the selected PHY register, and 0x2C reads back those 16 bits.
- R6: A data write to PHY register 0 with bit 15 set reloads every PHY register to its default. Register 0 then holds the written value with bits 15 and 12 cleared.
- R7: A data write to PHY register 0 with bit 12 set sets bit 5 of PHY register 1, and register 0 keeps bit 12 cleared.
- R8: After reset with the link down, PHY register 1 reads 0x7848, register 2 reads 0x0022, register 3 reads 0x1550, register 4 reads 0x01E1, and all other PHY registers read 0.
- R9: Within one clock of a change on link_up, bits 2 (link) and 5 (negotiation done) of PHY register 1 both equal link_up. A default reload sets them from link_up.
- R10: A write to offset 0x00 with bit 31 set reloads every PHY register to its default.
- R11: After reset the status and data registers read 0, and offsets with no register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| link_up | input | 1 | Link state reported by the line side |

## Verification
The hardest case to reach is the interaction between the side effects on PHY register 0 and register 1's live link bits. Examples are a reset write while the link is up, and a negotiation start while the link is down, where bit 5 must be set with bit 2 still clear. The bench reaches these by moving link_up between directed sequences and reading register 1 back through a selector write and a command write. The random phase mixes PHY addresses inside and outside the answering one over the plain registers and compares each read against a shadow copy.

// File: rtl/mdio_emu_pkg.sv
package mdio_emu_pkg;

   // byte offsets on the register bus
   localparam logic [7:0] OFS_CFG = 8'h00;
   localparam logic [7:0] OFS_CMD = 8'h24;
   localparam logic [7:0] OFS_ADR = 8'h28;
   localparam logic [7:0] OFS_CTL = 8'h2C;
   localparam logic [7:0] OFS_STS = 8'h30;

   // bit positions that carry behaviour
   localparam int CFG_SRST_BIT = 31;
   localparam int CMD_RD_BIT   = 0;
   localparam int PC_RST_BIT   = 15;
   localparam int PC_AN_BIT    = 12;
   localparam int PS_LINK_BIT  = 2;
   localparam int PS_ANOK_BIT  = 5;

   // reload values of the modelled transceiver
   localparam logic [15:0] PS_CAPS = 16'h7848;
   localparam logic [15:0] ID_HI   = 16'h0022;
   localparam logic [15:0] ID_LO   = 16'h1550;
   localparam logic [15:0] AD_CAPS = 16'h01E1;
   localparam logic [15:0] PC_SELF_CLR = 16'h9000;

   typedef struct packed {
      logic [4:0] phy;
      logic [4:0] regn;
   } mgmt_sel_t;

   function automatic logic [15:0] phy_default(input int unsigned idx, input logic link);
      logic [15:0] v;
      case (idx)
         1:       begin
                     v = PS_CAPS;
                     v[PS_LINK_BIT] = link;
                     v[PS_ANOK_BIT] = link;
                  end
         2:       v = ID_HI;
         3:       v = ID_LO;
         4:       v = AD_CAPS;
         default: v = 16'h0000;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/mdio_emu_regbus.sv
module mdio_emu_regbus
   import mdio_emu_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int BUS_W     = 32,
   parameter int DATA_W    = 16,
   parameter int PHY_ADDR  = 1,
   parameter int REG_COUNT = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   input  logic [DATA_W-1:0] file_rd,
   output logic [BUS_W-1:0]  bus_rdata,
   output mgmt_sel_t         sel,
   output logic              ctl_wr,
   output logic              soft_rst,
   output logic [DATA_W-1:0] status_q
);

   logic              hit_cfg, hit_cmd, hit_adr, hit_ctl;
   logic              phy_hit;
   logic [DATA_W-1:0] ctl_q;
   logic              unused_bits;

   assign hit_cfg = bus_wr && (bus_addr == ADDR_W'(OFS_CFG));
   assign hit_cmd = bus_wr && (bus_addr == ADDR_W'(OFS_CMD));
   assign hit_adr = bus_wr && (bus_addr == ADDR_W'(OFS_ADR));
   assign hit_ctl = bus_wr && (bus_addr == ADDR_W'(OFS_CTL));

   // selected transceiver answers and register number is inside the file
   assign phy_hit  = (sel.phy == 5'(PHY_ADDR)) && (32'(sel.regn) < REG_COUNT);
   assign ctl_wr   = hit_ctl && phy_hit;
   assign soft_rst = hit_cfg && bus_wdata[CFG_SRST_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel      <= '0;
         ctl_q    <= '0;
         status_q <= '0;
      end else begin
         if (hit_adr) begin
            sel.phy  <= bus_wdata[12:8];
            sel.regn <= bus_wdata[4:0];
         end
         if (hit_ctl) begin
            ctl_q <= bus_wdata[DATA_W-1:0];
         end
         if (hit_cmd && bus_wdata[CMD_RD_BIT]) begin
            status_q <= phy_hit ? file_rd : '1;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_ADR)) begin
         bus_rdata[12:8] = sel.phy;
         bus_rdata[4:0]  = sel.regn;
      end else if (bus_addr == ADDR_W'(OFS_CTL)) begin
         bus_rdata = BUS_W'(ctl_q);
      end else if (bus_addr == ADDR_W'(OFS_STS)) begin
         bus_rdata = BUS_W'(status_q);
      end
   end

   // bits of the write word that no register keeps
   assign unused_bits = ^bus_wdata;

endmodule

// File: rtl/mdio_emu_phy_file.sv
module mdio_emu_phy_file
   import mdio_emu_pkg::*;
#(
   parameter int REG_COUNT = 32,
   parameter int DATA_W    = 16,
   localparam int IDX_W    = $clog2(REG_COUNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              soft_rst,
   input  logic              link_up,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] reg0_q,
   output logic [DATA_W-1:0] reg1_q
);

   logic [REG_COUNT-1:0][DATA_W-1:0] ent;
   logic link_q;
   logic hit0, phy_rst, an_now, link_chg;

   assign hit0     = wr_en && (wr_idx == '0);
   assign phy_rst  = soft_rst || (hit0 && wr_data[PC_RST_BIT]);
   assign an_now   = hit0 && wr_data[PC_AN_BIT];
   assign link_chg = (link_up != link_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) link_q <= 1'b0;
      else        link_q <= link_up;
   end

   for (genvar i = 0; i < REG_COUNT; i++) begin : g_ent
      logic [DATA_W-1:0] q;
      logic              hit;
      assign hit    = wr_en && (wr_idx == IDX_W'(i));
      assign ent[i] = q;

      if (i == 0) begin : g_ctrl
         // control word: self-clearing reset and negotiation-start bits
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       q <= DATA_W'(phy_default(0, 1'b0));
            else if (hit)     q <= wr_data & ~DATA_W'(PC_SELF_CLR);
            else if (phy_rst) q <= DATA_W'(phy_default(0, link_up));
         end
      end else if (i == 1) begin : g_stat
         // status word: live link flags and instant negotiation
         logic [DATA_W-1:0] nxt;
         always_comb begin
            nxt = phy_rst ? DATA_W'(phy_default(1, link_up)) : q;
            if (link_chg) begin
               nxt[PS_LINK_BIT] = link_up;
               nxt[PS_ANOK_BIT] = link_up;
            end
            if (an_now) nxt[PS_ANOK_BIT] = 1'b1;
            if (hit)    nxt = wr_data;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= DATA_W'(phy_default(1, 1'b0));
            else        q <= nxt;
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       q <= DATA_W'(phy_default(i, 1'b0));
            else if (hit)     q <= wr_data;
            else if (phy_rst) q <= DATA_W'(phy_default(i, link_up));
         end
      end
   end

   assign rd_data = ent[rd_idx];
   assign reg0_q  = ent[0];
   assign reg1_q  = ent[1];

endmodule

// File: rtl/mdio_phy_emu.sv
module mdio_phy_emu
   import mdio_emu_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int BUS_W     = 32,
   parameter int DATA_W    = 16,
   parameter int REG_COUNT = 32,
   parameter int PHY_ADDR  = 1,
   localparam int IDX_W    = $clog2(REG_COUNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              link_up
);

   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must cover the highest register offset");
   end
   if (BUS_W < 32) begin : g_bad_bus
      $error("BUS_W must hold the soft reset bit");
   end
   if (DATA_W != 16) begin : g_bad_data
      $error("DATA_W must match the 16-bit management word");
   end
   if (REG_COUNT < 8 || REG_COUNT > 32 || (REG_COUNT & (REG_COUNT - 1)) != 0) begin : g_bad_cnt
      $error("REG_COUNT must be a power of two from 8 to 32");
   end
   if (PHY_ADDR < 0 || PHY_ADDR > 31) begin : g_bad_phy
      $error("PHY_ADDR must fit the 5-bit address field");
   end

   mgmt_sel_t         sel;
   logic              ctl_wr, soft_rst;
   logic [DATA_W-1:0] status_q, file_rd, phy_reg0, phy_reg1;
   logic [4:0]        sel_phy, sel_regn;

   assign sel_phy  = sel.phy;
   assign sel_regn = sel.regn;

   mdio_emu_regbus #(
      .ADDR_W(ADDR_W), .BUS_W(BUS_W), .DATA_W(DATA_W),
      .PHY_ADDR(PHY_ADDR), .REG_COUNT(REG_COUNT)
   ) u_regbus (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .file_rd(file_rd), .bus_rdata(bus_rdata),
      .sel(sel), .ctl_wr(ctl_wr), .soft_rst(soft_rst), .status_q(status_q)
   );

   mdio_emu_phy_file #(
      .REG_COUNT(REG_COUNT), .DATA_W(DATA_W)
   ) u_file (
      .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr),
      .wr_idx(sel_regn[IDX_W-1:0]), .wr_data(bus_wdata[DATA_W-1:0]),
      .soft_rst(soft_rst), .link_up(link_up),
      .rd_idx(sel_regn[IDX_W-1:0]), .rd_data(file_rd),
      .reg0_q(phy_reg0), .reg1_q(phy_reg1)
   );

endmodule

// File: rtl/mdio_phy_emu_chk.sv
module mdio_phy_emu_chk
   import mdio_emu_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 16,
   parameter int PHY_ADDR = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              wd_b0,
   input logic              wd_b12,
   input logic              wd_b15,
   input logic              link_up,
   input logic [4:0]        sel_phy,
   input logic [4:0]        sel_regn,
   input logic [DATA_W-1:0] status_q,
   input logic [DATA_W-1:0] phy_reg0,
   input logic [DATA_W-1:0] phy_reg1
);

   logic cmd_w, ctl_w, own_phy;
   assign cmd_w   = bus_wr && (bus_addr == ADDR_W'(OFS_CMD));
   assign ctl_w   = bus_wr && (bus_addr == ADDR_W'(OFS_CTL));
   assign own_phy = (sel_phy == 5'(PHY_ADDR));

   // R2
   miss_reads_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_w && wd_b0 && !own_phy) |=> (status_q == '1));

   // R3
   miss_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_w && !own_phy) |=> $stable(phy_reg0));

   // R4
   no_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_w && !wd_b0) |=> $stable(status_q));

   // R6
   rst_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_w && own_phy && sel_regn == 5'd0 && wd_b15) |=> !phy_reg0[PC_RST_BIT]);

   // R7
   an_instant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_w && own_phy && sel_regn == 5'd0 && wd_b12)
         |=> (phy_reg1[PS_ANOK_BIT] && !phy_reg0[PC_AN_BIT]));

   // R9
   link_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(link_up) && !bus_wr)
         |=> (phy_reg1[PS_LINK_BIT] == $past(link_up) && phy_reg1[PS_ANOK_BIT] == $past(link_up)));

endmodule

bind mdio_phy_emu mdio_phy_emu_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PHY_ADDR(PHY_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .wd_b0(bus_wdata[0]), .wd_b12(bus_wdata[12]), .wd_b15(bus_wdata[15]),
   .link_up(link_up), .sel_phy(sel_phy), .sel_regn(sel_regn),
   .status_q(status_q), .phy_reg0(phy_reg0), .phy_reg1(phy_reg1)
);

// File: tb/mdio_phy_emu_bench.sv
module mdio_phy_emu_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        link_up = 1'b0;

   int checks = 0;
   int failures = 0;
   logic [15:0] shadow [32];

   always #(CLK_PERIOD/2) clk = ~clk;

   mdio_phy_emu u_mdio_phy_emu (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .link_up(link_up)
   );

   function automatic logic [15:0] dflt(input int idx, input logic lk);
      case (idx)
         1:       return lk ? 16'h786C : 16'h7848;
         2:       return 16'h0022;
         3:       return 16'h1550;
         4:       return 16'h01E1;
         default: return 16'h0000;
      endcase
   endfunction

   task automatic reload_shadow(input logic lk);
      for (int i = 0; i < 32; i++) shadow[i] = dflt(i, lk);
   endtask

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic phy_rd(input int ph, input int rg, output logic [31:0] d);
      wr(8'h28, 32'((ph << 8) | rg));
      wr(8'h24, 32'h1);
      rd(8'h30, d);
   endtask

   task automatic phy_wr(input int ph, input int rg, input logic [15:0] d);
      wr(8'h28, 32'((ph << 8) | rg));
      wr(8'h2C, {16'hABCD, d});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int unused_seed;
      unused_seed = $urandom(32'h00C0FFEE);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state of bus registers
      rd(8'h30, v); check("R11 status", v, 32'h0);
      rd(8'h2C, v); check("R11 data", v, 32'h0);
      rd(8'h14, v); check("R11 unmapped", v, 32'h0);

      // R8 defaults, link down
      reload_shadow(1'b0);
      for (int r = 0; r < 8; r++) begin
         phy_rd(1, r, v); check("R8 default", v, {16'h0, shadow[r]});
      end
      phy_rd(1, 31, v); check("R8 default r31", v, 32'h0);

      // R1 selector fields
      wr(8'h28, 32'hFFFF_FFFF);
      rd(8'h28, v); check("R1 selector mask", v, 32'h0000_1F1F);
      wr(8'h28, 32'h0000_0A03);
      rd(8'h28, v); check("R1 selector value", v, 32'h0000_0A03);

      // R2 miss address
      phy_rd(0, 2, v); check("R2 miss ph0", v, 32'h0000_FFFF);
      phy_rd(31, 3, v); check("R2 miss ph31", v, 32'h0000_FFFF);

      // R5 data write and readback
      phy_wr(1, 9, 16'h5A5A);
      rd(8'h2C, v); check("R5 data readback", v, 32'h0000_5A5A);
      shadow[9] = 16'h5A5A;
      phy_rd(1, 9, v); check("R5 stored", v, 32'h0000_5A5A);

      // R4 command with bit 0 clear leaves status
      wr(8'h28, 32'h0000_0102);
      wr(8'h24, 32'hFFFF_FFFE);
      rd(8'h30, v); check("R4 hold", v, 32'h0000_5A5A);
      wr(8'h24, 32'h1);
      rd(8'h30, v); check("R4 capture", v, 32'h0000_0022);

      // R3 write at other address ignored
      phy_wr(2, 9, 16'h1111);
      phy_rd(1, 9, v); check("R3 ignored", v, 32'h0000_5A5A);

      // R9 link rises
      @(negedge clk); link_up = 1'b1;
      repeat (2) @(negedge clk);
      phy_rd(1, 1, v); check("R9 link up", v, 32'h0000_786C);

      // R6 reset bit with link up
      phy_wr(1, 7, 16'h0BEE);
      phy_wr(1, 0, 16'hB100);
      phy_rd(1, 0, v); check("R6 reg0 cleared bits", v, 32'h0000_2100);
      phy_rd(1, 7, v); check("R6 reloaded", v, 32'h0);
      phy_rd(1, 1, v); check("R6 reg1 link", v, 32'h0000_786C);
      phy_rd(1, 3, v); check("R6 id", v, 32'h0000_1550);
      shadow[9] = 16'h0;

      // R9 link falls
      @(negedge clk); link_up = 1'b0;
      repeat (2) @(negedge clk);
      phy_rd(1, 1, v); check("R9 link down", v, 32'h0000_7848);

      // R7 instant negotiation, link down
      phy_wr(1, 0, 16'h1040);
      phy_rd(1, 1, v); check("R7 an done", v, 32'h0000_7868);
      phy_rd(1, 0, v); check("R7 reg0", v, 32'h0000_0040);

      // R10 soft reset of the MAC
      phy_wr(1, 12, 16'hCAFE);
      phy_wr(1, 4, 16'h0000);
      wr(8'h00, 32'h8000_0000);
      phy_rd(1, 12, v); check("R10 plain", v, 32'h0);
      phy_rd(1, 4, v); check("R10 advert", v, 32'h0000_01E1);
      phy_rd(1, 1, v); check("R10 status", v, 32'h0000_7848);
      phy_rd(1, 0, v); check("R10 ctrl", v, 32'h0);

      // random mix over plain registers, R3 and R5
      reload_shadow(1'b0);
      for (int n = 0; n < 60; n++) begin
         int rg, ph;
         logic [15:0] d;
         rg = 5 + int'($urandom % 27);
         ph = ($urandom % 2 == 0) ? 1 : int'($urandom % 32);
         d  = 16'($urandom);
         phy_wr(ph, rg, d);
         if (ph == 1) shadow[rg] = d;
         phy_rd(1, rg, v);
         check(ph == 1 ? "R5 random" : "R3 random", v, {16'h0, shadow[rg]});
         if (ph != 1) begin
            phy_rd(ph, rg, v); check("R2 random", v, 32'h0000_FFFF);
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule